// File: doc/BRIEF.md
# Split High-Speed Correlation Accumulator

This block is the fast front end of a long integrator for correlation products. Each sample cycle it adds a small unsigned product into the low bits of a short counter that runs at the full sample rate. It never holds the whole sum. Once per dump period, measured in valid samples, it hands the counter's top bit to a slower accumulator downstream. That downstream stage can then live in a shared memory that is updated far less often. The product is already biased so that it is never negative, which means the counter only counts up. With four-level quantization, for example, the products are 0, 2, 3, 4 and 6.

There are two transfer modes. In clear mode the top bit is read and cleared in the same operation once every `DUMP_K` samples. In no-clear mode the top bit is read every `DUMP_K/2` samples and left as it is, and the downstream stage is assumed to be one bit wider. When an integration period ends, the block presents every counter bit above the low prescaler bits. This covers the case where the final output word reaches down into the fast counter. The whole counter is then cleared.

Top module: `hs_accum_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dump_stb`, `dump_bit`, `rd_stb`, `rd_word` and `ovf` are all zero.
- R2: A cycle with `samp_valid` high adds `samp_prod` into the counter. A cycle with `samp_valid` low adds nothing, whatever `samp_prod` holds, and it does not advance the dump period.
- R3: On the clock edge that accepts the P-th valid sample since the last dump or integration end, the block raises `dump_stb` for one cycle. P is `DUMP_K` in clear mode and `DUMP_K/2` in no-clear mode. At the same time `dump_bit` carries the counter's top bit as it stood before that sample was added. `dump_bit` is low whenever `dump_stb` is low.
- R4: In clear mode (`HALF_MODE=0`), a dump clears the top bit, and a sample on the same cycle is added to the cleared value, so no count is lost.
- R5: In no-clear mode (`HALF_MODE=1`), a dump leaves the counter unchanged, and the counter wraps modulo 2^`HS_W`.
- R6: A cycle with `integ_end` high sets `rd_stb` on the next cycle. `rd_word` then holds bits [`HS_W`-1:`PRE_W`] of the counter value after that cycle's update, including any same-cycle sample and dump clear. At all other times `rd_word` holds its last value.
- R7: `integ_end` clears the whole counter and restarts the dump period count. A dump that falls on the same cycle is still reported.
- R8: In clear mode, `ovf` pulses for one cycle when an addition carries out of the top bit, and the counter keeps the low `HS_W` bits of the sum. In no-clear mode `ovf` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Sample strobe |
| samp_prod | input | PROD_W | Unsigned product to add |
| integ_end | input | 1 | Last cycle of the integration period |
| dump_stb | output | 1 | Top-bit transfer strobe |
| dump_bit | output | 1 | Transferred top bit |
| rd_stb | output | 1 | End-of-integration readout strobe |
| rd_word | output | HS_W-PRE_W | Counter bits above the prescaler |
| ovf | output | 1 | Dump period violated (carry past the top bit) |

## Verification
Two events can land on the same cycle. The first is a dump together with the addition of a valid product; the second is a dump together with an integration end. The stimulus keeps `samp_valid` high without a break, so every dump cycle also carries a product, and it places `integ_end` on exactly the sample that completes a dump period. A behavioural reference model predicts the dump bit, the readout word and the overflow pulse for both transfer modes. A product lost at a dump, or a dump swallowed by a clear, shows up in a later readout word or dump bit.

// File: rtl/hs_accum_pkg.sv
package hs_accum_pkg;

  // Number of valid samples between transfers for the selected mode.
  function automatic int period_len(input int k, input bit half_mode);
    return half_mode ? (k / 2) : k;
  endfunction

  // Counter width needed to hold a period count 0..per-1.
  function automatic int cnt_width(input int per);
    return (per < 2) ? 1 : $clog2(per);
  endfunction

endpackage

// File: rtl/hs_period_ctr.sv
module hs_period_ctr #(
  parameter int PER = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_valid,
  input  logic integ_end,
  output logic dump_now
);
  localparam int CW = hs_accum_pkg::cnt_width(PER);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);

  logic [CW-1:0] cnt_q;

  assign dump_now = samp_valid && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (integ_end) begin
      cnt_q <= '0;
    end else if (samp_valid) begin
      cnt_q <= dump_now ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hs_counter_core.sv
module hs_counter_core #(
  parameter int HS_W      = 14,
  parameter int PRE_W     = 4,
  parameter int PROD_W    = 3,
  parameter bit HALF_MODE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  samp_valid,
  input  logic [PROD_W-1:0]     samp_prod,
  input  logic                  integ_end,
  input  logic                  dump_now,
  output logic [HS_W-1:0]       acc_q,
  output logic                  dump_stb,
  output logic                  dump_bit,
  output logic                  ovf,
  output logic [HS_W-PRE_W-1:0] rd_top
);
  localparam bit CLR_MODE = (HALF_MODE == 1'b0);

  logic [HS_W-1:0] base;
  logic [HS_W:0]   addend;
  logic [HS_W:0]   sum;

  generate
    if (HALF_MODE) begin : g_noclear
      assign base = acc_q;
    end else begin : g_clear
      assign base = dump_now ? {1'b0, acc_q[HS_W-2:0]} : acc_q;
    end
  endgenerate

  assign addend = samp_valid ? (HS_W+1)'(samp_prod) : '0;
  assign sum    = {1'b0, base} + addend;
  assign rd_top = sum[HS_W-1:PRE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      dump_stb <= 1'b0;
      dump_bit <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      acc_q    <= integ_end ? '0 : sum[HS_W-1:0];
      dump_stb <= dump_now;
      dump_bit <= dump_now & acc_q[HS_W-1];
      ovf      <= CLR_MODE & sum[HS_W];
    end
  end
endmodule

// File: rtl/hs_readout.sv
module hs_readout #(
  parameter int RD_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            integ_end,
  input  logic [RD_W-1:0] rd_top,
  output logic            rd_stb,
  output logic [RD_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb  <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_stb <= integ_end;
      if (integ_end) rd_word <= rd_top;
    end
  end
endmodule

// File: rtl/hs_accum_top.sv
module hs_accum_top #(
  parameter int HS_W      = 14,
  parameter int PRE_W     = 4,
  parameter int PROD_W    = 3,
  parameter int DUMP_K    = 8192,
  parameter bit HALF_MODE = 1'b0,
  localparam int RD_W     = HS_W - PRE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_valid,
  input  logic [PROD_W-1:0] samp_prod,
  input  logic              integ_end,
  output logic              dump_stb,
  output logic              dump_bit,
  output logic              rd_stb,
  output logic [RD_W-1:0]   rd_word,
  output logic              ovf
);
  localparam int PER = hs_accum_pkg::period_len(DUMP_K, HALF_MODE);

  logic            dump_now;
  logic [HS_W-1:0] acc_q;
  logic [RD_W-1:0] rd_top;

  hs_period_ctr #(.PER(PER)) u_per (
    .clk(clk), .rst(rst), .samp_valid(samp_valid),
    .integ_end(integ_end), .dump_now(dump_now)
  );

  hs_counter_core #(
    .HS_W(HS_W), .PRE_W(PRE_W), .PROD_W(PROD_W), .HALF_MODE(HALF_MODE)
  ) u_core (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_prod(samp_prod),
    .integ_end(integ_end), .dump_now(dump_now), .acc_q(acc_q),
    .dump_stb(dump_stb), .dump_bit(dump_bit), .ovf(ovf), .rd_top(rd_top)
  );

  hs_readout #(.RD_W(RD_W)) u_rd (
    .clk(clk), .rst(rst), .integ_end(integ_end), .rd_top(rd_top),
    .rd_stb(rd_stb), .rd_word(rd_word)
  );
endmodule

// File: rtl/hs_accum_chk.sv
module hs_accum_chk #(
  parameter int HS_W      = 14,
  parameter int RD_W      = 10,
  parameter int DUMP_K    = 8192,
  parameter bit HALF_MODE = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            samp_valid,
  input logic            integ_end,
  input logic            dump_stb,
  input logic            dump_bit,
  input logic            rd_stb,
  input logic [RD_W-1:0] rd_word,
  input logic            ovf,
  input logic [HS_W-1:0] acc_q
);
  localparam int PER = hs_accum_pkg::period_len(DUMP_K, HALF_MODE);
  localparam int CW  = hs_accum_pkg::cnt_width(PER) + 1;

  logic [CW-1:0] seen_q;
  logic          due;

  assign due = samp_valid && (seen_q == CW'(PER - 1));

  always_ff @(posedge clk) begin
    if (rst || integ_end) seen_q <= '0;
    else if (samp_valid) seen_q <= due ? '0 : seen_q + 1'b1;
  end

  AST_DUMP_ON_PERIOD: assert property (@(posedge clk) disable iff (rst)
    due |=> dump_stb); // R3
  AST_NO_EARLY_DUMP: assert property (@(posedge clk) disable iff (rst)
    !due |=> !dump_stb); // R3
  AST_DUMP_BIT_QUAL: assert property (@(posedge clk) disable iff (rst)
    dump_bit |-> dump_stb); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!samp_valid && !integ_end && !due && !HALF_MODE) |=> $stable(acc_q)); // R2
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    integ_end |=> (acc_q == '0)); // R7
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (rst)
    integ_end |=> rd_stb); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !integ_end |=> (!rd_stb && $stable(rd_word))); // R6
  AST_NO_OVF_HALF: assert property (@(posedge clk) disable iff (rst)
    HALF_MODE |-> !ovf); // R8
endmodule

bind hs_accum_top hs_accum_chk #(
  .HS_W(HS_W), .RD_W(RD_W), .DUMP_K(DUMP_K), .HALF_MODE(HALF_MODE)
) chk_i (
  .clk(clk), .rst(rst), .samp_valid(samp_valid), .integ_end(integ_end),
  .dump_stb(dump_stb), .dump_bit(dump_bit), .rd_stb(rd_stb),
  .rd_word(rd_word), .ovf(ovf), .acc_q(acc_q)
);

// File: tb/hs_accum_top_tb_top.sv
module hs_accum_top_tb_top;
  localparam int H = 6;
  localparam int PRE = 2;
  localparam int PW = 3;
  localparam int K = 8;
  localparam int RW = H - PRE;
  localparam int TOPV = 1 << (H - 1);
  localparam int MODV = 1 << H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic [PW-1:0] samp_prod = '0;
  logic integ_end = 1'b0;

  logic dstb [2];
  logic dbit [2];
  logic rstb [2];
  logic [RW-1:0] rword [2];
  logic ovf [2];

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  hs_accum_top #(.HS_W(H), .PRE_W(PRE), .PROD_W(PW), .DUMP_K(K), .HALF_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_prod(samp_prod),
    .integ_end(integ_end), .dump_stb(dstb[0]), .dump_bit(dbit[0]),
    .rd_stb(rstb[0]), .rd_word(rword[0]), .ovf(ovf[0]));

  hs_accum_top #(.HS_W(H), .PRE_W(PRE), .PROD_W(PW), .DUMP_K(K), .HALF_MODE(1'b1)) dut_h_i (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_prod(samp_prod),
    .integ_end(integ_end), .dump_stb(dstb[1]), .dump_bit(dbit[1]),
    .rd_stb(rstb[1]), .rd_word(rword[1]), .ovf(ovf[1]));

  // Behavioural reference model, one copy per transfer mode.
  int m_acc [2];
  int m_cnt [2];
  int e_dstb [2];
  int e_dbit [2];
  int e_rstb [2];
  int e_rword [2];
  int e_ovf [2];
  int ovf_seen = 0;
  int dump_ie_seen = 0;

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rst) begin
        m_acc[m] = 0; m_cnt[m] = 0; e_dstb[m] = 0; e_dbit[m] = 0;
        e_rstb[m] = 0; e_rword[m] = 0; e_ovf[m] = 0;
      end else begin
        int per, s, base;
        bit dump;
        per  = (m == 1) ? K / 2 : K;
        dump = samp_valid && (m_cnt[m] == per - 1);
        base = m_acc[m];
        if (dump && m == 0 && base >= TOPV) base = base - TOPV; // R4
        s = base + (samp_valid ? int'(samp_prod) : 0);        // R2
        e_ovf[m] = (m == 0 && s >= MODV) ? 1 : 0;             // R8
        if (e_ovf[m] != 0) ovf_seen++;
        s = s % MODV;                                          // R5 wrap
        e_dstb[m] = dump ? 1 : 0;
        e_dbit[m] = (dump && m_acc[m] >= TOPV) ? 1 : 0;
        e_rstb[m] = integ_end ? 1 : 0;
        if (integ_end) e_rword[m] = s >> PRE;
        if (integ_end && dump) dump_ie_seen++;
        m_acc[m] = integ_end ? 0 : s;                          // R7
        if (integ_end) m_cnt[m] = 0;
        else if (samp_valid) m_cnt[m] = dump ? 0 : m_cnt[m] + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        chk(m ? "R3 R5 dump_stb" : "R3 R4 dump_stb", int'(dstb[m]), e_dstb[m]);
        chk(m ? "R3 R5 dump_bit" : "R3 R4 dump_bit", int'(dbit[m]), e_dbit[m]);
        chk("R6 rd_stb", int'(rstb[m]), e_rstb[m]);
        chk("R2 R6 R7 rd_word", int'(rword[m]), e_rword[m]);
        chk("R8 ovf", int'(ovf[m]), e_ovf[m]);
      end
    end
  end

  task automatic drive(input bit v, input int p, input bit ie);
    @(negedge clk);
    samp_valid = v;
    samp_prod  = PW'(p);
    integ_end  = ie;
  endtask

  function automatic int pick_prod();
    case ($urandom % 5)
      0: return 0;
      1: return 2;
      2: return 3;
      3: return 4;
      default: return 6;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin // R1 during reset
      chk("R1 reset dump_stb", int'(dstb[m]), 0);
      chk("R1 reset rd_word", int'(rword[m]), 0);
      chk("R1 reset ovf", int'(ovf[m]), 0);
    end
    @(negedge clk);
    rst = 1'b0;

    // Phase A: mixed valid/idle samples, occasional integration end.
    for (int i = 0; i < 600; i++)
      drive(($urandom % 10) < 7, pick_prod(), ($urandom % 40) == 0);
    drive(1'b0, 0, 1'b1);

    // Phase B: idle cycles with a non-zero product must add nothing (R2).
    drive(1'b1, 3, 1'b0);
    for (int i = 0; i < 12; i++) drive(1'b0, 6, 1'b0);
    drive(1'b0, 6, 1'b1);

    // Phase C: unbroken valid stream; every dump meets a sample (R4) and
    // the largest product drives the clear-mode counter to overflow (R8).
    for (int i = 0; i < 64; i++) drive(1'b1, 6, 1'b0);
    drive(1'b0, 0, 1'b1);

    // Phase D: integration end on the sample that completes a period (R7).
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < K - 1; i++) drive(1'b1, pick_prod(), 1'b0);
      drive(1'b1, 6, 1'b1);
    end

    drive(1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 overflow provoked", (ovf_seen > 0) ? 1 : 0, 1);
    chk("R7 dump with integ_end provoked", (dump_ie_seen > 0) ? 1 : 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule